// File: doc/BRIEF.md
# Adaptive Flash Page Refresh Scheduler

This block walks every page of a flash array on a timed schedule so that retention errors are cleared before they pile up beyond what the error-correcting code can repair. When a refresh interval expires it starts a sweep. Page by page, in ascending address order, it issues a read, waits for the ECC engine to report whether the page decoded and how many bits it corrected, and then refreshes the page. A refresh either rewrites the same page in place, which costs no erase, or moves the corrected data to a fresh physical page.

The interval between sweeps comes from a ladder of tick counts selected by the block's current program/erase count. More wear selects a shorter interval. With one tick per day the default ladder is one year, three months, three weeks, three days and one day. The lookup is taken when a sweep starts and governs the wait that follows that sweep. A two-bit mode selects reprogram-only, remap-only or a hybrid policy. In hybrid, pages that needed many corrections are moved and the rest are rewritten in place. Pages the ECC cannot decode are reported and skipped. Only one flash command is in flight at any time.

Top module: `page_refresh_sched`

## Requirements
- R1: After reset, and before any tick arrives, no command is offered and the uncorrectable flag is low.
- R2: Until the first sweep has begun, the interval is the first ladder entry (365 ticks by default). The first command appears on that tick, counting from reset.
- R3: At the start of each sweep the scheduler latches ladder entry i, where i is the largest index with pe_count >= i*PE_STEP (default step 1000). Counts beyond the top step use the last entry. The latched value is the number of ticks to wait after that sweep ends. Ticks that arrive during a sweep are ignored.
- R4: A sweep visits pages 0 through N_PAGES-1 in ascending order. Each page starts with a read command (cmd_op 01) carrying that page address.
- R5: A command keeps cmd_valid, cmd_op and cmd_page unchanged until cmd_done is sampled high. No second command is offered before that.
- R6: After a read completes, no command is offered until ecc_valid is sampled. An ecc_valid pulse that arrives while a command is still pending is ignored.
- R7: If ECC reports the page as uncorrectable (ecc_ok low), uncorr_flag pulses for exactly one cycle with uncorr_page set to that page. No refresh command is issued for that page, and the next command is the read of the following page.
- R8: Mode 00 refreshes every decodable page in place (cmd_op 10). Mode 01 refreshes every decodable page by remapping it (cmd_op 11).
- R9: Modes 10 and 11 are hybrid. A page whose corrected-bit count is at least remap_thr is remapped (11). A page below that count is reprogrammed (10).
- R10: After the last page of a sweep, no further command appears until the latched interval has elapsed in ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time-base pulse |
| pe_count | input | PE_W | Program/erase count of the block |
| rf_mode | input | 2 | Refresh policy: 00 reprogram, 01 remap, 1x hybrid |
| remap_thr | input | CNT_W | Hybrid threshold on corrected bits |
| cmd_valid | output | 1 | Command pending toward the flash back end |
| cmd_op | output | 2 | 01 read, 10 reprogram in place, 11 remap |
| cmd_page | output | PAGE_AW | Page address of the pending command |
| cmd_done | input | 1 | Back end finished the pending command |
| ecc_valid | input | 1 | ECC verdict for the last read is present |
| ecc_ok | input | 1 | Page decoded successfully |
| ecc_nbits | input | CNT_W | Number of bits the ECC corrected |
| uncorr_flag | output | 1 | One-cycle pulse: page could not be corrected |
| uncorr_page | output | PAGE_AW | Address of the uncorrectable page |

## Verification
The assertions assume that the back end raises cmd_done only while a command is pending. They also assume that an ECC verdict for a read arrives once, after that read is done, and that rf_mode and remap_thr stay fixed during a sweep. The bench models the back end and honours all of this. The one exception is a deliberate stray ecc_valid pulse, which it drives only while a read is still pending so that R6 can be checked. It changes pe_count and the policy only between sweeps, so every expected command follows from the page index, the sweep number and the ladder arithmetic.

// File: rtl/rfr_pkg.sv
package rfr_pkg;

   typedef enum logic [1:0] {
      OP_NONE   = 2'b00,
      OP_READ   = 2'b01,
      OP_REPROG = 2'b10,
      OP_REMAP  = 2'b11
   } rfr_op_e;

   typedef enum logic [1:0] {
      ST_WAIT,
      ST_RD,
      ST_ECC,
      ST_WR
   } rfr_state_e;

   // mode 00: always in place, 01: always move, 1x: decide on error count
   function automatic rfr_op_e pick_action(input logic [1:0] mode, input logic many_errs);
      case (mode)
         2'b00:   return OP_REPROG;
         2'b01:   return OP_REMAP;
         default: return many_errs ? OP_REMAP : OP_REPROG;
      endcase
   endfunction

endpackage

// File: rtl/rfr_period_lut.sv
module rfr_period_lut #(
   parameter int unsigned PE_W             = 16,
   parameter int unsigned TICK_W           = 20,
   parameter int unsigned N_LVL            = 5,
   parameter int unsigned PE_STEP          = 1000,
   parameter int unsigned IVL_TICKS [N_LVL] = '{365, 91, 21, 3, 1}
) (
   input  logic [PE_W-1:0]   pe_count,
   output logic [TICK_W-1:0] period
);
   localparam longint PE_MAX = (longint'(1) << PE_W) - 1;

   initial begin
      assert (N_LVL >= 2) else $error("period ladder needs two levels");
      assert (PE_STEP > 0) else $error("PE_STEP must be non-zero");
      for (int i = 0; i < N_LVL; i++) begin
         assert (IVL_TICKS[i] > 0) else $error("ladder entry %0d is zero", i);
         assert (longint'(IVL_TICKS[i]) < (longint'(1) << TICK_W))
            else $error("ladder entry %0d exceeds TICK_W", i);
         if (i > 0)
            assert (IVL_TICKS[i] <= IVL_TICKS[i-1])
               else $error("ladder must not lengthen with wear");
      end
   end

   logic [N_LVL-1:0] hit;
   assign hit[0] = 1'b1;

   for (genvar g = 1; g < N_LVL; g++) begin : g_thr
      localparam longint THR = longint'(g) * longint'(PE_STEP);
      if (THR > PE_MAX) begin : g_unreach
         assign hit[g] = 1'b0;
      end else begin : g_cmp
         assign hit[g] = (pe_count >= PE_W'(THR));
      end
   end

   always_comb begin
      period = TICK_W'(IVL_TICKS[0]);
      for (int i = 1; i < N_LVL; i++)
         if (hit[i]) period = TICK_W'(IVL_TICKS[i]);
   end

endmodule

// File: rtl/rfr_tick_timer.sv
module rfr_tick_timer #(
   parameter int unsigned TICK_W       = 20,
   parameter int unsigned RESET_PERIOD = 365
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              arm,
   input  logic              load,
   input  logic [TICK_W-1:0] next_period,
   output logic              fire
);
   initial begin
      assert (RESET_PERIOD > 0) else $error("reset period must be non-zero");
   end

   logic [TICK_W-1:0] cnt_q;
   logic [TICK_W-1:0] period_q;

   assign fire = arm && tick && (cnt_q == period_q - TICK_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         period_q <= TICK_W'(RESET_PERIOD);
      end else begin
         if (load) period_q <= next_period;
         if (!arm || fire)  cnt_q <= '0;
         else if (tick)     cnt_q <= cnt_q + TICK_W'(1);
      end
   end

   AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < period_q); // R3

   AST_IDLE_WHEN_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> cnt_q == '0); // R3

endmodule

// File: rtl/rfr_page_walker.sv
module rfr_page_walker
   import rfr_pkg::*;
#(
   parameter int unsigned N_PAGES = 16,
   parameter int unsigned CNT_W   = 6,
   localparam int unsigned PAGE_AW = (N_PAGES > 1) ? $clog2(N_PAGES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   output logic               arm,
   output logic               sweep_start,
   input  logic [1:0]         rf_mode,
   input  logic [CNT_W-1:0]   remap_thr,
   output logic               cmd_valid,
   output logic [1:0]         cmd_op,
   output logic [PAGE_AW-1:0] cmd_page,
   input  logic               cmd_done,
   input  logic               ecc_valid,
   input  logic               ecc_ok,
   input  logic [CNT_W-1:0]   ecc_nbits,
   output logic               uncorr_flag,
   output logic [PAGE_AW-1:0] uncorr_page
);
   localparam bit POW2 = (N_PAGES == (1 << PAGE_AW));

   initial begin
      assert (N_PAGES >= 2) else $error("at least two pages required");
      assert (CNT_W >= 1) else $error("CNT_W must be positive");
   end

   rfr_state_e         state_q;
   logic [PAGE_AW-1:0] page_q;
   rfr_op_e            act_q;
   logic               uncorr_q;
   logic [PAGE_AW-1:0] upage_q;
   logic               is_last;
   logic               step_done;

   if (POW2) begin : g_last_pow2
      assign is_last = &page_q;
   end else begin : g_last_cmp
      assign is_last = (page_q == PAGE_AW'(N_PAGES - 1));
   end

   assign arm         = (state_q == ST_WAIT);
   assign sweep_start = arm && fire;
   assign step_done   = ((state_q == ST_ECC) && ecc_valid && !ecc_ok) ||
                        ((state_q == ST_WR) && cmd_done);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_WAIT;
         page_q   <= '0;
         act_q    <= OP_REPROG;
         uncorr_q <= 1'b0;
         upage_q  <= '0;
      end else begin
         uncorr_q <= 1'b0;
         case (state_q)
            ST_WAIT: if (fire) begin
               state_q <= ST_RD;
               page_q  <= '0;
            end
            ST_RD: if (cmd_done) state_q <= ST_ECC;
            ST_ECC: if (ecc_valid) begin
               if (!ecc_ok) begin
                  uncorr_q <= 1'b1;
                  upage_q  <= page_q;
               end else begin
                  act_q   <= pick_action(rf_mode, ecc_nbits >= remap_thr);
                  state_q <= ST_WR;
               end
            end
            default: ;
         endcase
         if (step_done) begin
            if (is_last) state_q <= ST_WAIT;
            else begin
               page_q  <= page_q + PAGE_AW'(1);
               state_q <= ST_RD;
            end
         end
      end
   end

   always_comb begin
      cmd_valid = (state_q == ST_RD) || (state_q == ST_WR);
      case (state_q)
         ST_RD:   cmd_op = OP_READ;
         ST_WR:   cmd_op = act_q;
         default: cmd_op = OP_NONE;
      endcase
   end

   assign cmd_page    = page_q;
   assign uncorr_flag = uncorr_q;
   assign uncorr_page = upage_q;

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_op) && $stable(cmd_page)); // R5

   AST_READ_THEN_ECC: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && (cmd_op == OP_READ) && cmd_done |=> !cmd_valid); // R6

   AST_REFRESH_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && (cmd_op != OP_READ) && cmd_done |=> !cmd_valid || (cmd_op == OP_READ)); // R4

   AST_UNCORR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      uncorr_flag |=> !uncorr_flag); // R7

   AST_UNCORR_NO_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
      uncorr_flag |-> !(cmd_valid && (cmd_op != OP_READ))); // R7

endmodule

// File: rtl/page_refresh_sched.sv
module page_refresh_sched #(
   parameter int unsigned N_PAGES           = 16,
   parameter int unsigned PE_W              = 16,
   parameter int unsigned CNT_W             = 6,
   parameter int unsigned TICK_W            = 20,
   parameter int unsigned N_LVL             = 5,
   parameter int unsigned PE_STEP           = 1000,
   parameter int unsigned IVL_TICKS [N_LVL] = '{365, 91, 21, 3, 1},
   localparam int unsigned PAGE_AW = (N_PAGES > 1) ? $clog2(N_PAGES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [PE_W-1:0]    pe_count,
   input  logic [1:0]         rf_mode,
   input  logic [CNT_W-1:0]   remap_thr,
   output logic               cmd_valid,
   output logic [1:0]         cmd_op,
   output logic [PAGE_AW-1:0] cmd_page,
   input  logic               cmd_done,
   input  logic               ecc_valid,
   input  logic               ecc_ok,
   input  logic [CNT_W-1:0]   ecc_nbits,
   output logic               uncorr_flag,
   output logic [PAGE_AW-1:0] uncorr_page
);
   logic [TICK_W-1:0] lut_period;
   logic              fire;
   logic              arm;
   logic              sweep_start;

   rfr_period_lut #(
      .PE_W(PE_W), .TICK_W(TICK_W), .N_LVL(N_LVL),
      .PE_STEP(PE_STEP), .IVL_TICKS(IVL_TICKS)
   ) u_lut (
      .pe_count (pe_count),
      .period   (lut_period)
   );

   rfr_tick_timer #(
      .TICK_W(TICK_W), .RESET_PERIOD(IVL_TICKS[0])
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .arm         (arm),
      .load        (sweep_start),
      .next_period (lut_period),
      .fire        (fire)
   );

   rfr_page_walker #(
      .N_PAGES(N_PAGES), .CNT_W(CNT_W)
   ) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire        (fire),
      .arm         (arm),
      .sweep_start (sweep_start),
      .rf_mode     (rf_mode),
      .remap_thr   (remap_thr),
      .cmd_valid   (cmd_valid),
      .cmd_op      (cmd_op),
      .cmd_page    (cmd_page),
      .cmd_done    (cmd_done),
      .ecc_valid   (ecc_valid),
      .ecc_ok      (ecc_ok),
      .ecc_nbits   (ecc_nbits),
      .uncorr_flag (uncorr_flag),
      .uncorr_page (uncorr_page)
   );

endmodule

// File: tb/tb_page_refresh_sched.sv
`timescale 1ns/1ps
module tb_page_refresh_sched;
   localparam int NP = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [15:0] pe_count = '0;
   logic [1:0]  rf_mode = 2'b00;
   logic [5:0]  remap_thr = '0;
   logic        cmd_valid;
   logic [1:0]  cmd_op;
   logic [3:0]  cmd_page;
   logic        cmd_done = 1'b0;
   logic        ecc_valid = 1'b0;
   logic        ecc_ok = 1'b0;
   logic [5:0]  ecc_nbits = '0;
   logic        uncorr_flag;
   logic [3:0]  uncorr_page;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   page_refresh_sched dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pe_count(pe_count),
      .rf_mode(rf_mode), .remap_thr(remap_thr),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_page(cmd_page),
      .cmd_done(cmd_done), .ecc_valid(ecc_valid), .ecc_ok(ecc_ok),
      .ecc_nbits(ecc_nbits), .uncorr_flag(uncorr_flag), .uncorr_page(uncorr_page)
   );

   task automatic chk(input bit cond, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int nbits_of(int p, int s);
      return (p * 5 + s * 3) % 16;
   endfunction
   function automatic bit ok_of(int p, int s);
      return ((p * 3 + s) % 8) != 5;
   endfunction
   function automatic int exp_act(int mode, int nb, int thr);
      if (mode == 0) return 2;
      if (mode == 1) return 3;
      return (nb >= thr) ? 3 : 2;
   endfunction

   // pulse ticks until a command appears; count them
   task automatic wait_period(input int exp, input string req);
      int n = 0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk(!cmd_valid, "R10", "idle gap cmd_valid", cmd_valid, 0);
      end
      while (!cmd_valid && n < 1000) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
         n++;
      end
      chk(n == exp, req, "ticks until sweep", n, exp);
   endtask

   task automatic wait_cmd();
      for (int k = 0; k < 50 && !cmd_valid; k++) @(negedge clk);
   endtask

   task automatic run_sweep(input int s, input int mode, input int thr);
      rf_mode = 2'(mode);
      remap_thr = 6'(thr);
      for (int p = 0; p < NP; p++) begin
         int nb = nbits_of(p, s);
         bit ok = ok_of(p, s);
         wait_cmd();
         chk(cmd_valid && cmd_op == 2'b01, "R4", "read op", cmd_op, 1);
         chk(cmd_page == 4'(p), "R4", "read page", cmd_page, p);
         // hold period: stray ECC pulse on page 2, stray tick on page 5
         if (p == 2) begin ecc_valid = 1'b1; ecc_ok = 1'b0; end
         if (p == 5) tick = 1'b1;
         @(negedge clk);
         ecc_valid = 1'b0; tick = 1'b0;
         @(negedge clk);
         chk(cmd_valid && cmd_op == 2'b01 && cmd_page == 4'(p), "R5",
             "read held until done", cmd_page, p);
         chk(!uncorr_flag, "R6", "stray ecc ignored", uncorr_flag, 0);
         cmd_done = 1'b1;
         @(negedge clk);
         cmd_done = 1'b0;
         chk(!cmd_valid, "R6", "no cmd awaiting ECC", cmd_valid, 0);
         @(negedge clk);
         chk(!cmd_valid, "R6", "still awaiting ECC", cmd_valid, 0);
         ecc_valid = 1'b1; ecc_ok = ok; ecc_nbits = 6'(nb);
         @(negedge clk);
         ecc_valid = 1'b0;
         if (!ok) begin
            chk(uncorr_flag && uncorr_page == 4'(p), "R7", "uncorr flag/page",
                uncorr_page, p);
            chk(!(cmd_valid && cmd_op != 2'b01), "R7", "no refresh on uncorr", cmd_op, 1);
            @(negedge clk);
            chk(!uncorr_flag, "R7", "flag one cycle", uncorr_flag, 0);
         end else begin
            int e = exp_act(mode, nb, thr);
            chk(cmd_valid && cmd_op == 2'(e), (mode < 2) ? "R8" : "R9",
                "refresh op", cmd_op, e);
            chk(cmd_page == 4'(p), "R8", "refresh page", cmd_page, p);
            @(negedge clk);
            chk(cmd_valid && cmd_op == 2'(e), "R5", "refresh held", cmd_op, e);
            cmd_done = 1'b1;
            @(negedge clk);
            cmd_done = 1'b0;
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         chk(!cmd_valid && !uncorr_flag, "R1", "reset quiet", cmd_valid, 0);
      end
      pe_count = 16'd2500;                 // level 2 -> 21
      wait_period(365, "R2");
      run_sweep(0, 0, 0);
      pe_count = 16'd4000;                 // level 4 -> 1
      wait_period(21, "R3");
      run_sweep(1, 1, 0);
      pe_count = 16'd999;                  // level 0 -> 365
      wait_period(1, "R3");
      run_sweep(2, 2, 5);
      pe_count = 16'd65535;                // clamp -> 1
      wait_period(365, "R3");
      run_sweep(3, 3, 0);
      pe_count = 16'd1000;                 // level 1 -> 91
      wait_period(1, "R3");
      run_sweep(4, 2, 10);
      wait_period(91, "R3");
      run_sweep(5, 3, 16);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk(!cmd_valid, "R10", "quiet after last page", cmd_valid, 0);
      end
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog run hung actual=1 expected=0");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule